// File: doc/BRIEF.md
# Bidirectional Shared Data FIFO

This block is one storage array that works as the transmit queue while data goes out to a card and as the receive queue while data comes back. Two run inputs choose the direction. While transmit runs, the system-bus side pushes words and the card-side data unit pops them. While receive runs, the card-side data unit pushes words and the bus side pops them. When neither input is active, both sides are locked out and the stored words stay in place. A flush input empties the queue.

Fill-level flags go to a status register. These are empty, data available, full, half-full and half-empty. Sticky overrun and underrun flags record misuse. A sticky direction-conflict flag records any cycle in which both run inputs were raised together. All flags and both read-data outputs are registered. Each one changes on the first clock edge after the stimulus that causes it.

Top module: `shared_dir_fifo`

## Requirements
- R1: With the default parameters the queue holds 32 words of 32 bits each. `full` asserts once 32 words are held. Words leave in the order they were accepted.
- R2: While `tx_run`=1 and `rx_run`=0, a `bus_wr` pulse stores `bus_wdata` and a `card_rd` pulse pops the oldest word. The popped word appears on `card_rdata` at the next clock edge. `card_wr` and `bus_rd` are ignored in this mode.
- R3: While `rx_run`=1 and `tx_run`=0, a `card_wr` pulse stores `card_wdata` and a `bus_rd` pulse pops the oldest word onto `bus_rdata` at the next clock edge. `bus_wr` and `card_rd` are ignored in this mode.
- R4: While both run inputs are 0, every read and write strobe is ignored. The flags, both read-data outputs and the stored words are left unchanged.
- R5: In any cycle with both run inputs at 1, every strobe is ignored and `dir_err` is set. `dir_err` stays at 1 until reset or flush.
- R6: `empty` is 1 exactly when no word is held. `data_avail` is its inverse. `empty` and `full` are never 1 together.
- R7: `half_full` is 1 when 16 or more words are held. `half_empty` is 1 when 16 or fewer words are held.
- R8: A write while `full` is dropped and sets the sticky `overrun` flag.
- R9: A read while `empty` pops nothing, drives zero onto the reading side's data output, and sets the sticky `underrun` flag.
- R10: When the queue is neither empty nor full, a read and a write in the same cycle both take effect and the held count does not change.
- R11: A `flush` pulse empties the queue and clears `overrun`, `underrun` and `dir_err`. Strobes in the flush cycle are ignored.
- R12: After reset `empty`=1 and `half_empty`=1, all other flags are 0, and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue and clears the sticky flags |
| tx_run | input | 1 | Transmit direction active |
| rx_run | input | 1 | Receive direction active |
| bus_wr | input | 1 | Bus-side write strobe (transmit) |
| bus_wdata | input | DATA_W | Bus-side write word |
| bus_rd | input | 1 | Bus-side read strobe (receive) |
| bus_rdata | output | DATA_W | Word last popped by the bus side |
| card_wr | input | 1 | Card-side write strobe (receive) |
| card_wdata | input | DATA_W | Card-side write word |
| card_rd | input | 1 | Card-side read strobe (transmit) |
| card_rdata | output | DATA_W | Word last popped by the card side |
| empty | output | 1 | No word held |
| data_avail | output | 1 | At least one word held |
| full | output | 1 | DEPTH words held |
| half_full | output | 1 | At least DEPTH/2 words held |
| half_empty | output | 1 | At most DEPTH/2 words held |
| overrun | output | 1 | Sticky: write attempted while full |
| underrun | output | 1 | Sticky: read attempted while empty |
| dir_err | output | 1 | Sticky: both run inputs raised together |

## Verification
Every result of this block, whether a flag, a sticky bit or a popped word, is due at the first rising edge after the cycle that holds the strobe. There is no result with a longer latency. The bench drives each stimulus on a falling edge, keeps it for one full cycle, and samples all outputs on the next falling edge. Each check therefore sees the state exactly one register stage after its cause, and always before the next stimulus is applied. Stimuli that must be ignored are checked in the same way. The bench samples the flags and read-data outputs those strobes could have changed.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TX    = 2'd1,
    MODE_RX    = 2'd2,
    MODE_CLASH = 2'd3
  } fifo_mode_e;
endpackage

// File: rtl/fifo_dir_ctrl.sv
module fifo_dir_ctrl
  import fifo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              tx_run,
  input  logic              rx_run,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              card_wr,
  input  logic [DATA_W-1:0] card_wdata,
  input  logic              card_rd,
  output fifo_mode_e        mode,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic              rd_to_bus
);
  always_comb begin
    mode = fifo_mode_e'({rx_run, tx_run});
    wr_req    = 1'b0;
    rd_req    = 1'b0;
    wr_data   = bus_wdata;
    rd_to_bus = 1'b0;
    unique case (mode)
      MODE_TX: begin
        wr_req = bus_wr;
        rd_req = card_rd;
      end
      MODE_RX: begin
        wr_req    = card_wr;
        wr_data   = card_wdata;
        rd_req    = bus_rd;
        rd_to_bus = 1'b1;
      end
      default: begin
        wr_req = 1'b0;
        rd_req = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_req,
  input  logic                     rd_req,
  input  logic                     clash,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic                     rd_en,
  output logic                     rd_zero,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     empty_q,
  output logic                     avail_q,
  output logic                     full_q,
  output logic                     hfull_q,
  output logic                     hempty_q,
  output logic                     ovr_q,
  output logic                     udr_q,
  output logic                     derr_q
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] wptr_q, rptr_q;
  logic          is_empty, is_full;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CNT_MAX);
  assign wr_en    = wr_req && !is_full  && !flush;
  assign rd_en    = rd_req && !is_empty && !flush;
  assign rd_zero  = rd_req && is_empty  && !flush;
  assign wr_addr  = wptr_q;
  assign rd_addr  = rptr_q;

  always_comb begin
    cnt_n = cnt_q;
    if (flush)
      cnt_n = '0;
    else if (wr_en && !rd_en)
      cnt_n = cnt_q + 1'b1;
    else if (rd_en && !wr_en)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_en) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (rd_en) rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      empty_q  <= 1'b1;
      avail_q  <= 1'b0;
      full_q   <= 1'b0;
      hfull_q  <= 1'b0;
      hempty_q <= 1'b1;
      ovr_q    <= 1'b0;
      udr_q    <= 1'b0;
      derr_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      empty_q  <= (cnt_n == '0);
      avail_q  <= (cnt_n != '0);
      full_q   <= (cnt_n == CNT_MAX);
      hfull_q  <= (cnt_n >= CNT_HALF);
      hempty_q <= (cnt_n <= CNT_HALF);
      if (flush) begin
        ovr_q  <= 1'b0;
        udr_q  <= 1'b0;
        derr_q <= 1'b0;
      end else begin
        ovr_q  <= ovr_q  | (wr_req && is_full);
        udr_q  <= udr_q  | rd_zero;
        derr_q <= derr_q | clash;
      end
    end
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic                     rd_zero,
  input  logic                     rd_to_bus,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        bus_q,
  output logic [DATA_W-1:0]        card_q
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      card_q <= '0;
    end else if (rd_to_bus) begin
      if (rd_en)        bus_q <= store[rd_addr];
      else if (rd_zero) bus_q <= '0;
    end else begin
      if (rd_en)        card_q <= store[rd_addr];
      else if (rd_zero) card_q <= '0;
    end
  end
endmodule

// File: rtl/shared_dir_fifo.sv
module shared_dir_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              tx_run,
  input  logic              rx_run,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              card_wr,
  input  logic [DATA_W-1:0] card_wdata,
  input  logic              card_rd,
  output logic [DATA_W-1:0] card_rdata,
  output logic              empty,
  output logic              data_avail,
  output logic              full,
  output logic              half_full,
  output logic              half_empty,
  output logic              overrun,
  output logic              underrun,
  output logic              dir_err
);
  localparam int AW = $clog2(DEPTH);

  fifo_mode_e        mode;
  logic              wr_req, rd_req, rd_to_bus;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en, rd_en, rd_zero;
  logic [AW-1:0]     wr_addr, rd_addr;

  fifo_dir_ctrl #(.DATA_W(DATA_W)) u_dir (
    .tx_run(tx_run), .rx_run(rx_run),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .card_wr(card_wr), .card_wdata(card_wdata), .card_rd(card_rd),
    .mode(mode), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rd_to_bus(rd_to_bus)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_req(wr_req), .rd_req(rd_req), .clash(mode == MODE_CLASH),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_zero(rd_zero),
    .rd_addr(rd_addr),
    .empty_q(empty), .avail_q(data_avail), .full_q(full),
    .hfull_q(half_full), .hempty_q(half_empty),
    .ovr_q(overrun), .udr_q(underrun), .derr_q(dir_err)
  );

  fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_zero(rd_zero), .rd_to_bus(rd_to_bus),
    .rd_addr(rd_addr), .bus_q(bus_rdata), .card_q(card_rdata)
  );
endmodule

// File: rtl/shared_dir_fifo_chk.sv
module shared_dir_fifo_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              tx_run,
  input logic              rx_run,
  input logic              bus_wr,
  input logic              card_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] card_rdata,
  input logic              empty,
  input logic              data_avail,
  input logic              full,
  input logic              half_full,
  input logic              half_empty,
  input logic              overrun,
  input logic              underrun,
  input logic              dir_err
);
  // R6
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R6
  avail_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    data_avail != empty);

  // R7
  full_half_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> (half_full && !half_empty));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(full));

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(empty));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_run && !rx_run && !flush) |=>
      ($stable(empty) && $stable(full) && $stable(bus_rdata) && $stable(card_rdata)));

  // R5
  clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_run && rx_run && !flush) |=> dir_err);

  // R10
  same_cycle_rw_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_run && !rx_run && bus_wr && card_rd && !empty && !full && !flush) |=>
      ($stable(empty) && $stable(full) && $stable(half_full) && $stable(half_empty)));
endmodule

bind shared_dir_fifo shared_dir_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .tx_run(tx_run), .rx_run(rx_run),
  .bus_wr(bus_wr), .card_rd(card_rd),
  .bus_rdata(bus_rdata), .card_rdata(card_rdata),
  .empty(empty), .data_avail(data_avail), .full(full),
  .half_full(half_full), .half_empty(half_empty),
  .overrun(overrun), .underrun(underrun), .dir_err(dir_err)
);

// File: tb/shared_dir_fifo_tb.sv
module shared_dir_fifo_tb;
  localparam int W = 32;
  localparam int D = 32;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, tx_run = 1'b0, rx_run = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, card_wr = 1'b0, card_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0, card_wdata = '0;
  logic [W-1:0] bus_rdata, card_rdata;
  logic empty, data_avail, full, half_full, half_empty, overrun, underrun, dir_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  shared_dir_fifo #(.DATA_W(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .tx_run(tx_run), .rx_run(rx_run),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .card_wr(card_wr), .card_wdata(card_wdata), .card_rd(card_rd), .card_rdata(card_rdata),
    .empty(empty), .data_avail(data_avail), .full(full), .half_full(half_full),
    .half_empty(half_empty), .overrun(overrun), .underrun(underrun), .dir_err(dir_err)
  );

  // fields: {tx,rx,bus_wr,bus_rd,card_wr,card_rd}, wdata, {exp_empty,exp_underrun}, exp_bus, exp_card
  localparam logic [103:0] VEC [NV] = '{
    {6'b101000, 32'h0000_00A1, 2'b00, 32'h0, 32'h0},            // R2 push
    {6'b101000, 32'h0000_00A2, 2'b00, 32'h0, 32'h0},            // R2 push
    {6'b100001, 32'h0,         2'b00, 32'h0, 32'h0000_00A1},    // R2 pop
    {6'b101001, 32'h0000_00A3, 2'b00, 32'h0, 32'h0000_00A2},    // R10 push+pop
    {6'b100001, 32'h0,         2'b10, 32'h0, 32'h0000_00A3},    // R2 pop to empty
    {6'b100001, 32'h0,         2'b11, 32'h0, 32'h0},            // R9 pop when empty
    {6'b001000, 32'h0000_0055, 2'b11, 32'h0, 32'h0},            // R4 idle write ignored
    {6'b010010, 32'h0000_00B1, 2'b01, 32'h0, 32'h0},            // R3 card push
    {6'b010100, 32'h0,         2'b11, 32'h0000_00B1, 32'h0},    // R3 bus pop
    {6'b011000, 32'h0000_0077, 2'b11, 32'h0000_00B1, 32'h0}     // R3 bus write ignored
  };

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (one rising edge later)
  task automatic step(input logic t, input logic r, input logic bw, input logic br,
                      input logic cw, input logic cr, input logic [W-1:0] wd, input logic fl);
    tx_run = t; rx_run = r; bus_wr = bw; bus_rd = br; card_wr = cw; card_rd = cr;
    bus_wdata = wd; card_wdata = wd; flush = fl;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; card_wr = 0; card_rd = 0; flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 empty", W'(empty), 1);
    chk("R12 half_empty", W'(half_empty), 1);
    chk("R12 other flags", W'({data_avail, full, half_full, overrun, underrun, dir_err}), 0);
    chk("R12 bus_rdata", bus_rdata, 0);
    chk("R12 card_rdata", card_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      v = VEC[i];
      step(v[103], v[102], v[101], v[100], v[99], v[98], v[97:66], 1'b0);
      chk($sformatf("R2/R3/R4/R9/R10 vec%0d empty", i), W'(empty), W'(v[65]));
      chk($sformatf("R6 vec%0d data_avail", i), W'(data_avail), W'(!v[65]));
      chk($sformatf("R9 vec%0d underrun", i), W'(underrun), W'(v[64]));
      chk($sformatf("R3 vec%0d bus_rdata", i), bus_rdata, v[63:32]);
      chk($sformatf("R2 vec%0d card_rdata", i), card_rdata, v[31:0]);
    end

    // R11 flush clears sticky flags
    step(0, 0, 0, 0, 0, 0, '0, 1'b1);
    chk("R11 underrun cleared", W'(underrun), 0);
    chk("R11 empty", W'(empty), 1);

    // R1 / R7 fill to capacity in transmit mode
    for (int i = 0; i < D; i++) begin
      step(1, 0, 1, 0, 0, 0, W'(32'h100 + i), 1'b0);
      if (i == 14) chk("R7 half_full at 15", W'(half_full), 0);
      if (i == 15) begin
        chk("R7 half_full at 16", W'(half_full), 1);
        chk("R7 half_empty at 16", W'(half_empty), 1);
      end
      if (i == 16) chk("R7 half_empty at 17", W'(half_empty), 0);
      if (i == 30) chk("R1 not full at 31", W'(full), 0);
    end
    chk("R1 full at 32", W'(full), 1);
    chk("R6 data_avail full", W'(data_avail), 1);
    // R8 write while full
    step(1, 0, 1, 0, 0, 0, 32'hDEAD_BEEF, 1'b0);
    chk("R8 overrun", W'(overrun), 1);
    chk("R8 still full", W'(full), 1);
    // R1 drain in order, dropped word absent
    for (int i = 0; i < D; i++) begin
      step(1, 0, 0, 0, 0, 1, '0, 1'b0);
      chk($sformatf("R1 order %0d", i), card_rdata, W'(32'h100 + i));
    end
    chk("R1 empty after drain", W'(empty), 1);
    chk("R8 overrun sticky", W'(overrun), 1);
    chk("R9 no underrun on drain", W'(underrun), 0);

    // R5 both run inputs: flagged, write blocked
    step(0, 0, 0, 0, 0, 0, '0, 1'b1);
    step(1, 1, 1, 0, 1, 0, 32'h0000_0099, 1'b0);
    chk("R5 dir_err", W'(dir_err), 1);
    chk("R5 write blocked", W'(empty), 1);
    step(1, 0, 0, 0, 0, 0, '0, 1'b0);
    chk("R5 dir_err sticky", W'(dir_err), 1);
    step(0, 0, 0, 0, 0, 0, '0, 1'b1);
    chk("R11 dir_err cleared", W'(dir_err), 0);
    chk("R11 overrun cleared", W'(overrun), 0);

    // R10 receive-side simultaneous push and pop
    step(0, 1, 0, 0, 1, 0, 32'h0000_0C01, 1'b0);
    step(0, 1, 0, 1, 1, 0, 32'h0000_0C02, 1'b0);
    chk("R10 bus_rdata", bus_rdata, 32'h0000_0C01);
    chk("R10 count kept", W'(empty), 0);
    step(0, 1, 0, 1, 0, 0, '0, 1'b0);
    chk("R10 second word", bus_rdata, 32'h0000_0C02);
    chk("R10 empty", W'(empty), 1);
    // R9 receive-side underrun returns zero
    step(0, 1, 0, 1, 0, 0, '0, 1'b0);
    chk("R9 bus zero", bus_rdata, 0);
    chk("R9 underrun rx", W'(underrun), 1);
    // R4 idle keeps contents
    step(0, 1, 0, 0, 1, 0, 32'h0000_0D01, 1'b0);
    step(0, 0, 0, 1, 0, 1, '0, 1'b0);
    chk("R4 idle read ignored", bus_rdata, 0);
    chk("R4 contents kept", W'(empty), 0);
    step(0, 1, 0, 1, 0, 0, '0, 1'b0);
    chk("R4 word survives idle", bus_rdata, 32'h0000_0D01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule